// File: doc/BRIEF.md
# Staged Supply Start-Up and Fault Supervisor

This controller brings three supply rails up one after another and then keeps watch over them. It takes a master enable, a supply-good flag from an undervoltage monitor, and one "rail above 80% of target" flag per rail. It drives an enable per rail, a shared soft-start ramp code, a flag that shows the internal timebase is running, and a ready indication. The ready indication models an open-drain pin: `rdy_pull` high means the pin is pulled low (ready), and low means the pin is released (not ready).

A free-running counter stands in for the external timing capacitor. Its period is `2**PERIOD_LOG2` clock cycles, and the same counter paces both the start-up stages and the fault timer. Start-up runs nine periods, three per rail: one ramp period followed by two settle periods. The rails start in a fixed order: boost first (`rail_en[0]`), then the negative regulator (`rail_en[1]`), then the positive regulator (`rail_en[2]`). Once the rails are running, a rail that drops out must stay out through a short deglitch window before it counts as a fault. A fault that is still present when one timer period ends shuts every rail off, and the block stays off until enable or supply is cycled.

Top module: `pseq_ctrl`

## Requirements
- R1: From the off state, a start begins on the first clock edge at which `en` and `uvlo_ok` are both high, whichever of the two rose last. After that edge `rail_en` is 3'b001 and `ramp_run` is 1.
- R2: With P = 2**PERIOD_LOG2, `rail_en[1]` turns on at the edge 3P cycles after the start edge, and `rail_en[2]` turns on at the edge 6P cycles after it. A higher-index rail is never on while a lower-index rail is off.
- R3: While the timebase runs, `ramp_code` equals the top RAMP_W bits of a counter that restarts at 0 on each period. The code is 0 on the start edge and reaches all ones in the last cycle of the period. When the timebase is held, `ramp_code` is 0.
- R4: At the edge 9P cycles after the start edge, if all three `rail_good` bits are 1, `rdy_pull` goes to 1 and `ramp_run` goes to 0. `rdy_pull` is 1 only while all three rails are enabled.
- R5: If any `rail_good` bit is 0 at that edge, `rdy_pull` stays 0, the rails stay on, and the timebase restarts from 0 as the fault timer.
- R6: During start-up the `rail_good` flags have no effect on `rail_en` or `rdy_pull`.
- R7: In the ready state, a `rail_good` bit must be low on DEGLITCH_CYC consecutive edges before `rdy_pull` drops to 0 and the fault timer starts. A shorter dropout leaves `rdy_pull` at 1.
- R8: If all flags are good again before the fault timer expires, the controller returns to ready on the next edge, with `rdy_pull` at 1 and `ramp_run` at 0. If the flags come back good on the last cycle of the fault-timer period, recovery wins over shutdown.
- R9: If a flag is still bad in the last cycle of the fault-timer period, `rail_en` becomes 3'b000 and stays there, even after the flags recover, until `en` or `uvlo_ok` goes low.
- R10: When `en` or `uvlo_ok` is low, `rail_en` and `rdy_pull` are 0 in the same cycle, without waiting for a clock edge. The next start runs the full nine-period sequence from the beginning.
- R11: A synchronous active-high `rst` puts the block in the off state. All outputs are then 0 and the ready pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Master on/off request |
| uvlo_ok | input | 1 | Supply above undervoltage threshold |
| rail_good | input | 3 | Per-rail flag: output above 80% of target (0 boost, 1 negative, 2 positive) |
| rail_en | output | 3 | Per-rail enable, same index order as `rail_good` |
| ramp_code | output | RAMP_W | Shared soft-start ramp code |
| ramp_run | output | 1 | Timebase running (start-up stage or fault timer) |
| rdy_pull | output | 1 | 1 = ready pin pulled low, 0 = released |

## Verification
Two events can fall on the same clock edge: expiry of the fault timer, and the rail flags recovering. The bench holds one flag low until the final cycle of the timer period, raises it exactly then, and expects the block to return to ready with all rails on rather than latch off. A second collision is between the deglitch counter and a flag that recovers one edge before the window closes; the bench expects `rdy_pull` to stay at 1 in that case. The same-cycle shutdown on losing `en` or `uvlo_ok` is checked between clock edges, before any register could react.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [2:0] {
    PS_OFF,
    PS_START,
    PS_RUN,
    PS_FWAIT,
    PS_TRIP
  } pseq_state_e;
endpackage

// File: rtl/pseq_timebase.sv
module pseq_timebase #(
  parameter int PERIOD_LOG2 = 20,
  parameter int RAMP_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              run_nxt,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              period_end
);
  localparam int CW = PERIOD_LOG2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || !run_nxt) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign ramp_code  = cnt_q[CW-1 -: RAMP_W];
  assign period_end = run && (cnt_q == {CW{1'b1}});

  // R3: the counter wraps to zero after the last cycle of a period
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (period_end && run_nxt) |=> (cnt_q == '0));
  // R3: the counter is held at zero whenever the timebase was stopped
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pseq_deglitch.sv
module pseq_deglitch #(
  parameter int DG_CYC = 3750
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic bad,
  output logic trip
);
  localparam int W = (DG_CYC > 1) ? $clog2(DG_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(DG_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm || !bad) cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign trip = arm && bad && (cnt_q == LAST);

  // R7: a nonzero count means the fault was also present on the previous edge
  assert_dg_history_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $past(bad && arm));
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl #(
  parameter int PERIOD_LOG2  = 20,
  parameter int RAMP_W       = 8,
  parameter int DEGLITCH_CYC = 3750
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              uvlo_ok,
  input  logic [2:0]        rail_good,
  output logic [2:0]        rail_en,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              ramp_run,
  output logic              rdy_pull
);
  import pseq_pkg::*;

  localparam int NRAIL     = 3;
  localparam int PER_RAIL  = 3;
  localparam int NPHASE    = NRAIL * PER_RAIL;
  localparam int PH_W      = $clog2(NPHASE);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NPHASE - 1);

  pseq_state_e     state_q, state_n;
  logic [PH_W-1:0] phase_q, phase_n;
  logic            go, all_good, pend, trip, run_now, run_nxt;

  assign go       = en && uvlo_ok;
  assign all_good = &rail_good;
  assign run_now  = (state_q == PS_START) || (state_q == PS_FWAIT);
  assign run_nxt  = (state_n == PS_START) || (state_n == PS_FWAIT);

  pseq_timebase #(.PERIOD_LOG2(PERIOD_LOG2), .RAMP_W(RAMP_W)) u_tb (
    .clk(clk), .rst(rst), .run(run_now), .run_nxt(run_nxt),
    .ramp_code(ramp_code), .period_end(pend)
  );

  pseq_deglitch #(.DG_CYC(DEGLITCH_CYC)) u_dg (
    .clk(clk), .rst(rst), .arm(state_q == PS_RUN), .bad(!all_good), .trip(trip)
  );

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    if (!go) begin
      state_n = PS_OFF;
      phase_n = '0;
    end else begin
      unique case (state_q)
        PS_OFF: begin
          state_n = PS_START;
          phase_n = '0;
        end
        PS_START: if (pend) begin
          if (phase_q == LAST_PH) begin
            state_n = all_good ? PS_RUN : PS_FWAIT;
            phase_n = '0;
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end
        PS_RUN:   if (trip) state_n = PS_FWAIT;
        PS_FWAIT: begin
          if (all_good)  state_n = PS_RUN;
          else if (pend) state_n = PS_TRIP;
        end
        PS_TRIP:  state_n = PS_TRIP;
        default:  state_n = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_OFF;
      phase_q <= '0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
    end
  end

  for (genvar k = 0; k < NRAIL; k++) begin : g_rail
    localparam logic [PH_W-1:0] ON_PH = PH_W'(k * PER_RAIL);
    assign rail_en[k] = go &&
      (((state_q == PS_START) && (phase_q >= ON_PH)) ||
       (state_q == PS_RUN) || (state_q == PS_FWAIT));
  end

  assign ramp_run = run_now;
  assign rdy_pull = go && (state_q == PS_RUN);

  // R2: rails come up strictly in index order
  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    (rail_en[2] |-> rail_en[1]) and (rail_en[1] |-> rail_en[0]));
  // R4: ready is only signalled with all rails up and the timebase held
  assert_rdy_full_R4: assert property (@(posedge clk) disable iff (rst)
    rdy_pull |-> (rail_en == 3'b111) && !ramp_run);
  // R9: the shutdown latch holds while enable and supply stay good
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_TRIP && go) |=> (state_q == PS_TRIP) && (rail_en == 3'b000));
  // R10: losing enable or supply always returns to the off state
  assert_drop_off_R10: assert property (@(posedge clk) disable iff (rst)
    !go |=> (state_q == PS_OFF));
  // R5: a fault timer entry from start-up only happens at the end of the last phase
  assert_start_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_START && state_n == PS_FWAIT) |-> (phase_q == LAST_PH) && pend);
endmodule

// File: tb/tb_pseq_ctrl.sv
module tb_pseq_ctrl;
  localparam int PL2 = 4;
  localparam int RW  = 3;
  localparam int DG  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0, uvlo_ok = 1'b0;
  logic [2:0]    rail_good = 3'b000;
  logic [2:0]    rail_en;
  logic [RW-1:0] ramp_code;
  logic          ramp_run, rdy_pull;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  pseq_ctrl #(.PERIOD_LOG2(PL2), .RAMP_W(RW), .DEGLITCH_CYC(DG)) dut (
    .clk(clk), .rst(rst), .en(en), .uvlo_ok(uvlo_ok), .rail_good(rail_good),
    .rail_en(rail_en), .ramp_code(ramp_code), .ramp_run(ramp_run), .rdy_pull(rdy_pull)
  );

  // row: en, uvlo_ok, rail_good[2:0], edges[7:0], exp rail_en[2:0], exp rdy, exp run
  localparam int NV = 17;
  localparam logic [17:0] TAB [0:NV-1] = '{
    {1'b1, 1'b1, 3'b000, 8'd1,  3'b001, 1'b0, 1'b1},  // R1 start
    {1'b1, 1'b1, 3'b000, 8'd47, 3'b001, 1'b0, 1'b1},  // R6 flags ignored
    {1'b1, 1'b1, 3'b000, 8'd1,  3'b011, 1'b0, 1'b1},  // R2 negative on at 3P
    {1'b1, 1'b1, 3'b000, 8'd47, 3'b011, 1'b0, 1'b1},  // R6
    {1'b1, 1'b1, 3'b000, 8'd1,  3'b111, 1'b0, 1'b1},  // R2 positive on at 6P
    {1'b1, 1'b1, 3'b111, 8'd47, 3'b111, 1'b0, 1'b1},  // R2 still starting
    {1'b1, 1'b1, 3'b111, 8'd1,  3'b111, 1'b1, 1'b0},  // R4 ready at 9P
    {1'b1, 1'b1, 3'b110, 8'd3,  3'b111, 1'b1, 1'b0},  // R7 inside window
    {1'b1, 1'b1, 3'b111, 8'd1,  3'b111, 1'b1, 1'b0},  // R7 glitch filtered
    {1'b1, 1'b1, 3'b011, 8'd4,  3'b111, 1'b0, 1'b1},  // R7 full window
    {1'b1, 1'b1, 3'b111, 8'd1,  3'b111, 1'b1, 1'b0},  // R8 recovery
    {1'b1, 1'b1, 3'b101, 8'd4,  3'b111, 1'b0, 1'b1},  // R7 second fault
    {1'b1, 1'b1, 3'b101, 8'd15, 3'b111, 1'b0, 1'b1},  // R9 not yet expired
    {1'b1, 1'b1, 3'b101, 8'd1,  3'b000, 1'b0, 1'b0},  // R9 expiry
    {1'b1, 1'b1, 3'b111, 8'd5,  3'b000, 1'b0, 1'b0},  // R9 latched
    {1'b0, 1'b1, 3'b111, 8'd1,  3'b000, 1'b0, 1'b0},  // R10 enable low
    {1'b1, 1'b1, 3'b000, 8'd1,  3'b001, 1'b0, 1'b1}   // R1 restart
  };

  function automatic string row_req(int i);
    case (i)
      0, 16:            return "R1";
      1, 3:             return "R6";
      2, 4, 5:          return "R2";
      6:                return "R4";
      7, 8, 9, 11:      return "R7";
      10:               return "R8";
      12, 13, 14:       return "R9";
      default:          return "R10";
    endcase
  endfunction

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] e_rail, logic e_rdy, logic e_run);
    n_run++;
    if (rail_en !== e_rail || rdy_pull !== e_rdy || ramp_run !== e_run) begin
      n_fail++;
      $display("FAIL %s: rail_en=%b rdy_pull=%b ramp_run=%b, expected %b %b %b",
               req, rail_en, rdy_pull, ramp_run, e_rail, e_rdy, e_run);
    end
  endtask

  task automatic chk_ramp(string req, logic [RW-1:0] e_code);
    n_run++;
    if (ramp_code !== e_code) begin
      n_fail++;
      $display("FAIL %s: ramp_code=%0d, expected %0d", req, ramp_code, e_code);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    edges(2);
    chk("R11", 3'b000, 1'b0, 1'b0);
    chk_ramp("R11", '0);
    rst = 1'b0;
    edges(1);
    chk("R11", 3'b000, 1'b0, 1'b0);  // idle without enable

    for (int i = 0; i < NV; i++) begin
      en        = TAB[i][17];
      uvlo_ok   = TAB[i][16];
      rail_good = TAB[i][15:13];
      edges(int'(TAB[i][12:5]));
      chk(row_req(i), TAB[i][4:2], TAB[i][1], TAB[i][0]);
    end

    // R11: reset wins over a running start
    rst = 1'b1;
    edges(1);
    chk("R11", 3'b000, 1'b0, 1'b0);
    chk_ramp("R11", '0);

    // R3: ramp code over the first period
    rst = 1'b0;
    edges(1);
    chk("R1", 3'b001, 1'b0, 1'b1);
    chk_ramp("R3", 3'd0);
    edges(8);
    chk_ramp("R3", 3'd4);
    edges(7);
    chk_ramp("R3", 3'd7);
    edges(1);
    chk_ramp("R3", 3'd0);
    chk("R3", 3'b001, 1'b0, 1'b1);

    // R10: supply loss drops rails between edges
    uvlo_ok = 1'b0;
    #1;
    chk("R10", 3'b000, 1'b0, 1'b1);
    edges(1);
    chk("R10", 3'b000, 1'b0, 1'b0);
    chk_ramp("R10", '0);

    // R1: start when supply returns with enable already high
    uvlo_ok   = 1'b1;
    rail_good = 3'b011;
    edges(1);
    chk("R1", 3'b001, 1'b0, 1'b1);

    // R5: a rail still low at the end of start-up enters the fault timer
    edges(144);
    chk("R5", 3'b111, 1'b0, 1'b1);
    chk_ramp("R5", 3'd0);
    edges(15);
    chk("R5", 3'b111, 1'b0, 1'b1);
    chk_ramp("R5", 3'd7);

    // R8: recovery on the final timer cycle beats expiry
    rail_good = 3'b111;
    edges(1);
    chk("R8", 3'b111, 1'b1, 1'b0);
    edges(20);
    chk("R8", 3'b111, 1'b1, 1'b0);

    // R10: enable low from ready drops rails and ready between edges
    en = 1'b0;
    #1;
    chk("R10", 3'b000, 1'b0, 1'b0);
    edges(1);
    chk("R10", 3'b000, 1'b0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule